// File: doc/BRIEF.md
# Audio Sample FIFO with Watermark Requests

This block buffers 32-bit audio subframe words that a DMA engine pushes through a single data register, and releases them one per sample strobe towards a serial audio bus. Software programs it through a control/status register (enable, sample-group size, parity regeneration, flush, single-shot reset and three sticky error flags) and a threshold register holding two pairs of 6-bit watermarks.

The fill level drives two request lines. The DMA request and the panic request each assert when the level falls to or below their own low watermark and release once it climbs to their own high watermark. This hysteresis keeps the DMA engine from toggling on every word. Errors are sticky until software writes 1 to the flag's bit. A write into a full FIFO is dropped and flagged. A strobe that finds no data is flagged as late when it falls at the start of a sample group, and as an underflow when it falls in the middle of one.

Top module: `afifo_dreq`

## Requirements
- R1: Words written with reg_sel=2 leave in write order, one per strobe while enabled. out_valid pulses and out_word carries the word in the cycle after the strobe edge.
- R2: fifo_empty and control bit 10 are high when no words are held. fifo_full and control bit 11 are high when DEPTH words are held.
- R3: A data write while the FIFO is full is discarded, leaving the stored words unchanged, and sets the overflow flag at control bit 1.
- R4: Control bits 7:4 give the sample-group size (0 counts as 1). An enabled strobe on an empty FIFO sets data-late (bit 15) at the first word of a group, and sets underflow (bit 2) when part of the group has already been drained.
- R5: Writing 1 to control bit 1, 2 or 15 clears that flag, and writing 0 leaves it set. A new error event in the same cycle as the clear wins.
- R6: While enable (control bit 3) is clear, strobes drain nothing and both request lines are low.
- R7: The threshold register (reg_sel=1) holds the DMA high watermark in bits 13:8 and the DMA low watermark in bits 5:0. dma_req sets when the level is at or below the low watermark and clears when the level reaches the high watermark. It follows the level one cycle later.
- R8: panic_req behaves in the same way with its high watermark in bits 29:24 and its low watermark in bits 21:16.
- R9: Writing 1 to control bit 9 empties the FIFO in one cycle, keeps the error flags, and reads back as 0.
- R10: Writing 1 to control bit 0 empties the FIFO and clears all three error flags, and reads back as 0. The other fields of the same write take effect.
- R11: With control bit 8 set, bit 31 of each drained word is replaced by the XOR of bits 30:0, so the word has even parity. With bit 8 clear, the word passes through unchanged.
- R12: After reset the control register reads 0x400 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 thresholds, 2 data, 3 none |
| wr_data | input | 32 | Register write data |
| samp_strobe | input | 1 | Sample strobe from the serial bus side |
| ctrl_rdata | output | 32 | Control/status register read value |
| out_valid | output | 1 | A drained word is on out_word |
| out_word | output | 32 | Drained audio word |
| dma_req | output | 1 | DMA refill request |
| panic_req | output | 1 | Urgent refill request |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
The watermark logic is driven by a fill that climbs from empty through both high marks and then drains back past both low marks. This separates each request's set point from its release point and shows that the level held between the marks is kept rather than recomputed. A fill to exactly DEPTH followed by one extra write, and a full drain, tell a dropped word from a stored one. Empty strobes at a group start and inside a two-word group tell data-late from underflow. Flush and single-shot reset are issued with errors already set, which shows which of the two keeps the flags.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_THR  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int B_RST   = 0;
    localparam int B_OVF   = 1;
    localparam int B_UNF   = 2;
    localparam int B_EN    = 3;
    localparam int B_CHLO  = 4;
    localparam int B_PAR   = 8;
    localparam int B_FLUSH = 9;
    localparam int B_EMPTY = 10;
    localparam int B_FULL  = 11;
    localparam int B_LATE  = 15;

    localparam int TW = 6;

    typedef struct packed {
        logic       par;
        logic [3:0] chan;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [TW-1:0] pan_hi;
        logic [TW-1:0] pan_lo;
        logic [TW-1:0] dma_hi;
        logic [TW-1:0] dma_lo;
    } thr_t;

    typedef struct packed {
        logic late;
        logic unf;
        logic ovf;
    } err_t;

    function automatic logic [31:0] fix_parity(input logic [31:0] w, input logic gen);
        logic [31:0] r;
        r = w;
        if (gen) r[31] = ^w[30:0];
        return r;
    endfunction

    function automatic thr_t thr_unpack(input logic [31:0] d);
        thr_t t;
        t.pan_hi = d[29:24];
        t.pan_lo = d[21:16];
        t.dma_hi = d[13:8];
        t.dma_lo = d[5:0];
        return t;
    endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (level == LW'(DEPTH));
    assign empty    = (level == '0);
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/afifo_mark.sv
module afifo_mark #(
    parameter int LW = 6,
    parameter int TW = 6,
    localparam int CW = (LW > TW) ? LW : TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [LW-1:0] level,
    input  logic [TW-1:0] lo,
    input  logic [TW-1:0] hi,
    output logic          req
);
    logic [CW-1:0] lv, lo_x, hi_x;
    assign lv   = CW'(level);
    assign lo_x = CW'(lo);
    assign hi_x = CW'(hi);

    always_ff @(posedge clk) begin
        if (rst || !enable)  req <= 1'b0;
        else if (lv <= lo_x) req <= 1'b1;
        else if (lv >= hi_x) req <= 1'b0;
    end
endmodule

// File: rtl/afifo_dreq.sv
module afifo_dreq
    import afifo_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int DMA_LO0  = 8,
    parameter int DMA_HI0  = 16,
    parameter int PAN_LO0  = 2,
    parameter int PAN_HI0  = 4,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] wr_data,
    input  logic        samp_strobe,
    output logic [31:0] ctrl_rdata,
    output logic        out_valid,
    output logic [31:0] out_word,
    output logic        dma_req,
    output logic        panic_req,
    output logic        fifo_full,
    output logic        fifo_empty
);
    reg_sel_e sel;
    ctrl_t    ctrl;
    thr_t     thr;
    err_t     err, err_ev;
    logic     ctrl_wr, thr_wr, data_wr, clr, push, pop, strobe_en;
    logic [3:0]    slot, grp;
    logic [31:0]   pop_data;
    logic [LW-1:0] level;

    assign sel     = reg_sel_e'(reg_sel);
    assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
    assign thr_wr  = reg_wr && (sel == SEL_THR);
    assign data_wr = reg_wr && (sel == SEL_DATA);
    assign clr     = ctrl_wr && (wr_data[B_FLUSH] || wr_data[B_RST]);

    assign strobe_en = samp_strobe && ctrl.en && !clr;
    assign push      = data_wr && !fifo_full;
    assign pop       = strobe_en && !fifo_empty;
    assign grp       = (ctrl.chan == 4'd0) ? 4'd1 : ctrl.chan;

    assign err_ev.ovf  = data_wr && fifo_full;
    assign err_ev.late = strobe_en && fifo_empty && (slot == 4'd0);
    assign err_ev.unf  = strobe_en && fifo_empty && (slot != 4'd0);

    afifo_store #(.W(32), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(clr),
        .push(push), .push_data(wr_data),
        .pop(pop), .pop_data(pop_data),
        .level(level), .full(fifo_full), .empty(fifo_empty)
    );

    logic [TW-1:0] lo_a [2];
    logic [TW-1:0] hi_a [2];
    logic [1:0]    req_a;
    assign lo_a[0] = thr.dma_lo;
    assign hi_a[0] = thr.dma_hi;
    assign lo_a[1] = thr.pan_lo;
    assign hi_a[1] = thr.pan_hi;

    for (genvar g = 0; g < 2; g++) begin : g_mark
        afifo_mark #(.LW(LW), .TW(TW)) u_mark (
            .clk(clk), .rst(rst), .enable(ctrl.en),
            .level(level), .lo(lo_a[g]), .hi(hi_a[g]), .req(req_a[g])
        );
    end
    assign dma_req   = req_a[0];
    assign panic_req = req_a[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            thr  <= '{pan_hi: TW'(PAN_HI0), pan_lo: TW'(PAN_LO0),
                      dma_hi: TW'(DMA_HI0), dma_lo: TW'(DMA_LO0)};
        end else begin
            if (ctrl_wr) begin
                ctrl.en   <= wr_data[B_EN];
                ctrl.chan <= wr_data[B_CHLO +: 4];
                ctrl.par  <= wr_data[B_PAR];
            end
            if (thr_wr) thr <= thr_unpack(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || (ctrl_wr && wr_data[B_RST])) begin
            err <= '0;
        end else begin
            err.ovf  <= err_ev.ovf  | (err.ovf  & ~(ctrl_wr & wr_data[B_OVF]));
            err.unf  <= err_ev.unf  | (err.unf  & ~(ctrl_wr & wr_data[B_UNF]));
            err.late <= err_ev.late | (err.late & ~(ctrl_wr & wr_data[B_LATE]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                slot <= '0;
        else if (pop)                  slot <= (slot + 4'd1 >= grp) ? 4'd0 : slot + 4'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= pop;
            if (pop) out_word <= fix_parity(pop_data, ctrl.par);
        end
    end

    always_comb begin
        ctrl_rdata                = '0;
        ctrl_rdata[B_OVF]         = err.ovf;
        ctrl_rdata[B_UNF]         = err.unf;
        ctrl_rdata[B_EN]          = ctrl.en;
        ctrl_rdata[B_CHLO +: 4]   = ctrl.chan;
        ctrl_rdata[B_PAR]         = ctrl.par;
        ctrl_rdata[B_EMPTY]       = fifo_empty;
        ctrl_rdata[B_FULL]        = fifo_full;
        ctrl_rdata[B_LATE]        = err.late;
    end
endmodule

// File: rtl/afifo_dreq_chk.sv
module afifo_dreq_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] wr_data,
    input logic        samp_strobe,
    input logic [31:0] ctrl_rdata,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        dma_req,
    input logic        panic_req,
    input logic        fifo_full,
    input logic        fifo_empty
);
    p_full_empty_r2: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd2 && fifo_full) |=> ctrl_rdata[1]);

    p_late_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[15] && !(reg_wr && reg_sel == 2'd0 && (wr_data[15] || wr_data[0])))
        |=> ctrl_rdata[15]);

    p_req_off_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[3] |=> (!dma_req && !panic_req));

    p_no_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (samp_strobe && !ctrl_rdata[3]) |=> !out_valid);

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd0 && wr_data[9]) |=> fifo_empty);

    p_parity_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(ctrl_rdata[8])) |-> (^out_word == 1'b0));
endmodule

bind afifo_dreq afifo_dreq_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
    .samp_strobe(samp_strobe), .ctrl_rdata(ctrl_rdata), .out_valid(out_valid),
    .out_word(out_word), .dma_req(dma_req), .panic_req(panic_req),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/afifo_dreq_tb.sv
module afifo_dreq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        samp_strobe = 1'b0;
    logic [31:0] ctrl_rdata, out_word;
    logic        out_valid, dma_req, panic_req, fifo_full, fifo_empty;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    afifo_dreq u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
        .samp_strobe(samp_strobe), .ctrl_rdata(ctrl_rdata), .out_valid(out_valid),
        .out_word(out_word), .dma_req(dma_req), .panic_req(panic_req),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; wr_data = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic push(input logic [31:0] d);
        wr(2'd2, d);
    endtask

    task automatic strobe();
        @(negedge clk);
        samp_strobe = 1'b1;
        @(negedge clk);
        samp_strobe = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R12 ctrl", ctrl_rdata, 32'h400);
        check("R12 dma", {31'b0, dma_req}, 0);
        check("R12 panic", {31'b0, panic_req}, 0);
        check("R2 empty", {31'b0, fifo_empty}, 1);
    endtask

    task automatic t_order();
        wr(2'd0, 32'h18);
        push(32'hA1); push(32'hB2); push(32'hC3);
        strobe(); check("R1 word0", out_word, 32'hA1); check("R1 valid", {31'b0, out_valid}, 1);
        strobe(); check("R1 word1", out_word, 32'hB2);
        strobe(); check("R1 word2", out_word, 32'hC3);
        tick();   check("R1 valid pulse", {31'b0, out_valid}, 0);
        check("R1 no errors", ctrl_rdata & 32'h8006, 0);
    endtask

    task automatic t_marks();
        wr(2'd1, (32'd4 << 24) | (32'd1 << 16) | (32'd6 << 8) | 32'd3);
        wr(2'd0, 32'h218);
        tick(); check("R7 set empty", {31'b0, dma_req}, 1); check("R8 set empty", {31'b0, panic_req}, 1);
        push(1); push(2); tick();
        check("R7 lvl2", {31'b0, dma_req}, 1); check("R8 hold lvl2", {31'b0, panic_req}, 1);
        push(3); push(4); tick();
        check("R8 release lvl4", {31'b0, panic_req}, 0); check("R7 lvl4", {31'b0, dma_req}, 1);
        push(5); push(6); tick();
        check("R7 release lvl6", {31'b0, dma_req}, 0);
        strobe(); tick(); check("R7 hold lvl5", {31'b0, dma_req}, 0);
        strobe(); strobe(); tick(); check("R7 set lvl3", {31'b0, dma_req}, 1);
        check("R8 hold lvl3", {31'b0, panic_req}, 0);
        strobe(); tick(); check("R8 hold lvl2", {31'b0, panic_req}, 0);
        strobe(); tick(); check("R8 set lvl1", {31'b0, panic_req}, 1);
    endtask

    task automatic t_disable();
        wr(2'd0, 32'h10);
        tick();
        check("R6 dma low", {31'b0, dma_req}, 0);
        check("R6 panic low", {31'b0, panic_req}, 0);
        strobe();
        check("R6 no drain", {31'b0, out_valid}, 0);
        check("R6 word kept", {31'b0, fifo_empty}, 0);
    endtask

    task automatic t_full();
        wr(2'd0, 32'h210);
        for (int i = 0; i < 32; i++) push(100 + i);
        check("R2 full port", {31'b0, fifo_full}, 1);
        check("R2 full bit", ctrl_rdata & 32'hC02, 32'h800);
        push(32'hDEAD);
        check("R3 overflow flag", ctrl_rdata[1], 1);
        wr(2'd0, 32'h18);
        for (int i = 0; i < 32; i++) begin
            strobe();
            check("R3 stored word", out_word, 100 + i);
        end
        check("R2 empty after drain", ctrl_rdata & 32'hC00, 32'h400);
    endtask

    task automatic t_w1c();
        wr(2'd0, 32'h18);
        check("R5 write 0 keeps", ctrl_rdata[1], 1);
        wr(2'd0, 32'h1A);
        check("R5 write 1 clears", ctrl_rdata[1], 0);
    endtask

    task automatic t_late();
        strobe();
        check("R4 late set", ctrl_rdata[15], 1);
        check("R4 no underflow", ctrl_rdata[2], 0);
        wr(2'd0, 32'h8018);
        check("R5 late cleared", ctrl_rdata[15], 0);
    endtask

    task automatic t_underflow();
        wr(2'd0, 32'h28);
        push(32'h55);
        strobe(); check("R4 first slot", out_word, 32'h55);
        strobe();
        check("R4 underflow set", ctrl_rdata[2], 1);
        check("R4 not late", ctrl_rdata[15], 0);
    endtask

    task automatic t_flush();
        push(7); push(8); push(9);
        wr(2'd0, 32'h228);
        check("R9 emptied", {31'b0, fifo_empty}, 1);
        check("R9 errors kept", ctrl_rdata[2], 1);
        check("R9 reads zero", ctrl_rdata[9], 0);
    endtask

    task automatic t_softreset();
        push(7); push(8);
        wr(2'd0, 32'h19);
        check("R10 ctrl after reset", ctrl_rdata, 32'h418);
    endtask

    task automatic t_parity();
        wr(2'd0, 32'h118);
        push(32'h0000_0001); push(32'h8000_0003);
        strobe(); check("R11 parity set", out_word, 32'h8000_0001);
        strobe(); check("R11 parity cleared", out_word, 32'h0000_0003);
        wr(2'd0, 32'h18);
        push(32'h8000_0000);
        strobe(); check("R11 pass through", out_word, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset_state();
        t_order();
        t_marks();
        t_disable();
        t_full();
        t_w1c();
        t_late();
        t_underflow();
        t_flush();
        t_softreset();
        t_parity();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule